// File: doc/BRIEF.md
# Programmable Interrupt Controller Unit

This block collects eight interrupt request lines and presents one interrupt output to a host processor. The host sets it up and controls it through a byte-wide register port that has two addresses. The even address accepts the word that starts setup, and it also accepts run-time commands. The odd address accepts the setup words that follow and, after setup, the interrupt mask.

A rising edge on a request line is latched as a pending request. Unmasked pending requests are ranked by fixed priority, with level 0 highest. A request is offered to the processor only when it outranks every level that is currently in service. When the processor pulses its acknowledge input, the winning level moves from pending to in service, and the block returns an 8-bit vector one cycle later. The upper bits of the vector come from a programmed base and the low three bits hold the level number.

The service of a level is ended by a specific end-of-interrupt command. In automatic mode the service ends by itself at the acknowledge. If a request disappears before the acknowledge arrives, the block returns the vector of the lowest-priority level and marks nothing as in service.

Top module: `pic8_unit`

## Requirements
- R1: After reset the mask reads 0xFF, the pending and in-service sets are empty, the even-address read returns the pending set, and intr is low.
- R2: An even-address write with bit 4 set starts setup, empties the pending and in-service sets, selects the pending set for even reads and turns automatic mode off. The next odd writes are taken in order as the vector base, then the cascade word (skipped when bit 1 of the start word is 1), then the mode word (taken only when bit 0 of the start word is 1). None of these words changes the mask. Odd writes after the sequence load the mask.
- R3: An acknowledge pulse yields, on the following cycle, vec_out = {base[7:3], level[2:0]} with vec_vld high for exactly that one cycle.
- R4: When bit 1 of the mode word is 1 (automatic mode), an acknowledged level is not left in service, so an equal or lower priority request can be granted next.
- R5: A mask bit of 1 blocks that level from intr and from being granted. The pending set still records the request, and an odd-address read returns the mask.
- R6: A request becomes pending on a rising edge of its line. It stops being pending when it is granted or when its line returns low.
- R7: Among the unmasked pending levels, the lowest-numbered level is granted.
- R8: A level is granted only if its number is lower than every in-service level. Otherwise intr stays low and the lower-priority request waits.
- R9: An even-address write of 0x60 + L, where bits 7:5 are 011 and bits 2:0 give L, clears the in-service bit of level L and no other bit.
- R10: An even-address write with bit 4 at 0 and bit 3 at 1 is a read-select command. When bits 1:0 are 11 it selects the in-service set for even reads; when they are 10 it selects the pending set; when bit 1 is 0 the selection is unchanged.
- R11: An acknowledge with no grantable request returns {base[7:3], 3'b111} and sets no in-service bit. This holds even when level 7 is masked.
- R12: intr is high exactly when some unmasked pending level outranks every in-service level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 even, 1 odd |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read address: 0 even, 1 odd |
| rd_data | output | 8 | Read data (combinational) |
| irq_in | input | 8 | Request lines, bit i is level i |
| inta | input | 1 | One-cycle acknowledge pulse |
| intr | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector of the last acknowledge |
| vec_vld | output | 1 | vec_out is new this cycle |

## Verification
A single-level sweep raises each line alone. It separates the vector formation and the pending-to-in-service move of each level from any effect of ranking. A sweep over every ordered pair of lines shows whether the lower-numbered level wins, and whether the loser is held back until the winner's specific end-of-interrupt. A raise of level 5 followed by level 2 while 5 is in service shows that preemption nests.

All 256 mask values are applied with all eight lines raised. This shows that the grant follows the lowest unmasked bit, and that the mask hides requests from intr but not from the pending read. A request that drops before acknowledge, once with level 7 masked, separates the spurious vector from a real grant. Repeated setup sequences with different start words show that the cascade and mode words are skipped or consumed correctly and that automatic mode leaves nothing in service.

// File: rtl/pic8_pkg.sv
package pic8_pkg;

    // Setup word sequencer position
    typedef enum logic [1:0] {
        ST_READY = 2'd0,
        ST_BASE  = 2'd1,
        ST_CASC  = 2'd2,
        ST_MODE  = 2'd3
    } seq_e;

    // Command field encodings on the even address
    localparam logic [2:0] CMD_SPEC_EOI = 3'b011;

endpackage

// File: rtl/pic8_prio.sv
// Fixed-priority resolver: lowest index wins, gated by the in-service set.
module pic8_prio #(
    parameter int N  = 8,
    parameter int LW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [N-1:0]  isr,
    output logic          any,
    output logic [LW-1:0] idx,
    output logic [N-1:0]  oh
);
    logic          req_found;
    logic [LW-1:0] req_idx;
    logic          isr_found;
    logic [LW-1:0] isr_idx;

    always_comb begin
        req_found = 1'b0;
        req_idx   = '0;
        isr_found = 1'b0;
        isr_idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                req_found = 1'b1;
                req_idx   = LW'(i);
            end
            if (isr[i]) begin
                isr_found = 1'b1;
                isr_idx   = LW'(i);
            end
        end
        any = req_found && (!isr_found || (req_idx < isr_idx));
        idx = req_idx;
        oh  = any ? (N'(1) << req_idx) : '0;
    end

endmodule

// File: rtl/pic8_regif.sv
// Register port decoder: setup word sequencer, mask, commands.
module pic8_regif
    import pic8_pkg::*;
#(
    parameter int N  = 8,
    parameter int DW = 8,
    parameter int LW = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [DW-1:0]    wr_data,
    output logic [N-1:0]     mask,
    output logic [DW-1:LW]   base,
    output logic             aeoi,
    output logic             sel_isr,
    output logic             init_pulse,
    output logic [N-1:0]     eoi_oh
);
    typedef struct packed {
        seq_e             seq;
        logic             single;
        logic             need_mode;
        logic [DW-1:LW]   base;
        logic             aeoi;
        logic             sel_isr;
        logic [N-1:0]     mask;
    } regs_t;

    localparam regs_t REGS_RST = '{
        seq:       ST_READY,
        single:    1'b0,
        need_mode: 1'b0,
        base:      '0,
        aeoi:      1'b0,
        sel_isr:   1'b0,
        mask:      '1
    };

    regs_t regs_d, regs_q;
    logic  init_d;
    logic [N-1:0] eoi_d;

    always_comb begin
        regs_d = regs_q;
        init_d = 1'b0;
        eoi_d  = '0;
        if (wr_en) begin
            if (!wr_addr) begin
                if (wr_data[4]) begin
                    regs_d.seq       = ST_BASE;
                    regs_d.single    = wr_data[1];
                    regs_d.need_mode = wr_data[0];
                    regs_d.aeoi      = 1'b0;
                    regs_d.sel_isr   = 1'b0;
                    init_d           = 1'b1;
                end else if (wr_data[3]) begin
                    if (wr_data[1]) begin
                        regs_d.sel_isr = wr_data[0];
                    end
                end else if (wr_data[7:5] == CMD_SPEC_EOI) begin
                    eoi_d = N'(1) << wr_data[LW-1:0];
                end
            end else begin
                unique case (regs_q.seq)
                    ST_READY: regs_d.mask = wr_data[N-1:0];
                    ST_BASE: begin
                        regs_d.base = wr_data[DW-1:LW];
                        if (!regs_q.single) begin
                            regs_d.seq = ST_CASC;
                        end else if (regs_q.need_mode) begin
                            regs_d.seq = ST_MODE;
                        end else begin
                            regs_d.seq = ST_READY;
                        end
                    end
                    ST_CASC: begin
                        // cascade word is consumed; no wiring to other units here
                        regs_d.seq = regs_q.need_mode ? ST_MODE : ST_READY;
                    end
                    ST_MODE: begin
                        regs_d.aeoi = wr_data[1];
                        regs_d.seq  = ST_READY;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= REGS_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign mask       = regs_q.mask;
    assign base       = regs_q.base;
    assign aeoi       = regs_q.aeoi;
    assign sel_isr    = regs_q.sel_isr;
    assign init_pulse = init_d;
    assign eoi_oh     = eoi_d;

    // R2: every odd write inside the setup sequence moves the sequencer on
    a_r2_seq_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr && regs_q.seq != ST_READY) |=> (regs_q.seq != $past(regs_q.seq)))
        else $error("a_r2_seq_advance");

    // R5: the mask only changes through an odd write made outside the setup sequence
    a_r5_mask_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr && regs_q.seq == ST_READY) |=> $stable(regs_q.mask))
        else $error("a_r5_mask_stable");

endmodule

// File: rtl/pic8_core.sv
// Pending/in-service state, acknowledge handling, vector register.
module pic8_core #(
    parameter int N  = 8,
    parameter int DW = 8,
    parameter int LW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    irq_in,
    input  logic            ack,
    input  logic [N-1:0]    mask,
    input  logic [DW-1:LW]  base,
    input  logic            aeoi,
    input  logic            init_pulse,
    input  logic [N-1:0]    eoi_oh,
    output logic [N-1:0]    irr,
    output logic [N-1:0]    isr,
    output logic            intr,
    output logic [DW-1:0]   vec,
    output logic            vec_vld
);
    typedef struct packed {
        logic [N-1:0]  prev;
        logic [N-1:0]  irr;
        logic [N-1:0]  isr;
        logic [DW-1:0] vec;
        logic          vld;
    } st_t;

    st_t st_d, st_q;

    logic [N-1:0]  req;
    logic          g_any;
    logic [LW-1:0] g_idx;
    logic [N-1:0]  g_oh;
    logic [N-1:0]  rising;

    assign req = st_q.irr & ~mask;

    pic8_prio #(.N(N), .LW(LW)) prio_i (
        .req (req),
        .isr (st_q.isr),
        .any (g_any),
        .idx (g_idx),
        .oh  (g_oh)
    );

    always_comb begin
        st_d      = st_q;
        rising    = irq_in & ~st_q.prev;
        st_d.prev = irq_in;
        st_d.irr  = (st_q.irr | rising) & irq_in;
        st_d.isr  = st_q.isr & ~eoi_oh;
        st_d.vld  = 1'b0;
        if (ack) begin
            st_d.vld = 1'b1;
            if (g_any) begin
                st_d.irr = st_d.irr & ~g_oh;
                if (!aeoi) begin
                    st_d.isr = st_d.isr | g_oh;
                end
                st_d.vec = {base, g_idx};
            end else begin
                st_d.vec = {base, LW'(N - 1)};
            end
        end
        if (init_pulse) begin
            st_d.irr = '0;
            st_d.isr = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irr     = st_q.irr;
    assign isr     = st_q.isr;
    assign intr    = g_any;
    assign vec     = st_q.vec;
    assign vec_vld = st_q.vld;

    // R3: an acknowledge is answered by a valid vector on the next cycle
    a_r3_vec_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> vec_vld)
        else $error("a_r3_vec_follows_ack");

    a_r3_vld_single: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |=> !vec_vld)
        else $error("a_r3_vld_single");

    // R11: an acknowledge without a grant returns the last level and adds nothing in service
    a_r11_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !g_any && !init_pulse) |=>
            ((vec[LW-1:0] == LW'(N - 1)) && ((isr & ~$past(isr)) == '0)))
        else $error("a_r11_spurious");

    // R4: automatic mode never leaves a newly acknowledged level in service
    a_r4_aeoi_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && aeoi) |=> ((isr & ~$past(isr)) == '0))
        else $error("a_r4_aeoi_clean");

    // R8: after a normal grant no higher-priority level is in service
    a_r8_nested: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && g_any && !aeoi && !init_pulse) |=>
            ((isr & ($past(g_oh) - N'(1))) == '0))
        else $error("a_r8_nested");

    // R9: a specific end-of-interrupt leaves that level out of service
    a_r9_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ((|eoi_oh) && !ack) |=> ((isr & $past(eoi_oh)) == '0))
        else $error("a_r9_eoi_clears");

    // R12: intr only with an unmasked pending level behind it
    a_r12_intr_backed: assert property (@(posedge clk) disable iff (!rst_n)
        intr |-> (|(irr & ~mask)))
        else $error("a_r12_intr_backed");

endmodule

// File: rtl/pic8_unit.sv
// Top: eight-level programmable interrupt controller.
module pic8_unit #(
    parameter int N  = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic [N-1:0]  irq_in,
    input  logic          inta,
    output logic          intr,
    output logic [DW-1:0] vec_out,
    output logic          vec_vld
);
    localparam int LW = $clog2(N);

    logic [N-1:0]   mask;
    logic [DW-1:LW] base;
    logic           aeoi;
    logic           sel_isr;
    logic           init_pulse;
    logic [N-1:0]   eoi_oh;
    logic [N-1:0]   irr;
    logic [N-1:0]   isr;

    pic8_regif #(.N(N), .DW(DW), .LW(LW)) regif_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .mask       (mask),
        .base       (base),
        .aeoi       (aeoi),
        .sel_isr    (sel_isr),
        .init_pulse (init_pulse),
        .eoi_oh     (eoi_oh)
    );

    pic8_core #(.N(N), .DW(DW), .LW(LW)) core_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_in     (irq_in),
        .ack        (inta),
        .mask       (mask),
        .base       (base),
        .aeoi       (aeoi),
        .init_pulse (init_pulse),
        .eoi_oh     (eoi_oh),
        .irr        (irr),
        .isr        (isr),
        .intr       (intr),
        .vec        (vec_out),
        .vec_vld    (vec_vld)
    );

    always_comb begin
        if (rd_addr) begin
            rd_data = DW'(mask);
        end else if (sel_isr) begin
            rd_data = DW'(isr);
        end else begin
            rd_data = DW'(irr);
        end
    end

endmodule

// File: tb/pic8_unit_tb_top.sv
module pic8_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_addr = 1'b0;
    logic [7:0] rd_data;
    logic [7:0] irq = 8'h00;
    logic       inta = 1'b0;
    logic       intr;
    logic [7:0] vec_out;
    logic       vec_vld;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    pic8_unit dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .irq_in  (irq),
        .inta    (inta),
        .intr    (intr),
        .vec_out (vec_out),
        .vec_vld (vec_vld)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic do_ack(output logic [7:0] v, output logic vl);
        @(negedge clk);
        inta = 1'b1;
        @(negedge clk);
        inta = 1'b0;
        v  = vec_out;
        vl = vec_vld;
    endtask

    task automatic drive(input logic [7:0] val);
        @(negedge clk);
        irq = val;
        @(negedge clk);
    endtask

    function automatic logic [2:0] lowest_zero(input logic [7:0] m);
        logic [2:0] r = 3'd0;
        for (int i = 7; i >= 0; i--) begin
            if (!m[i]) r = 3'(i);
        end
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic       vl;
        logic [7:0] r;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(1'b1, r); chk("R1 mask after reset", r, 8'hFF);
        rd(1'b0, r); chk("R1 pending after reset", r, 8'h00);
        chk("R1 intr after reset", {7'd0, intr}, 8'h00);

        // R2 full setup: base 0x08, cascade word, normal end-of-interrupt
        wr(1'b0, 8'h11); wr(1'b1, 8'h08); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
        rd(1'b1, r); chk("R2 setup words leave mask", r, 8'hFF);
        wr(1'b1, 8'h00);
        rd(1'b1, r); chk("R5 mask load", r, 8'h00);

        // single-level sweep
        for (int l = 0; l < 8; l++) begin
            drive(8'(1 << l));
            rd(1'b0, r); chk("R6 edge latched", r, 8'(1 << l));
            chk("R12 intr with pending", {7'd0, intr}, 8'h01);
            do_ack(v, vl);
            chk("R3 vector", v, 8'h08 | 8'(l));
            chk("R3 vector valid", {7'd0, vl}, 8'h01);
            rd(1'b0, r); chk("R6 grant clears pending", r, 8'h00);
            chk("R12 intr after grant", {7'd0, intr}, 8'h00);
            wr(1'b0, 8'h0B);
            rd(1'b0, r); chk("R10 in-service read", r, 8'(1 << l));
            wr(1'b0, 8'h60 | 8'(l));
            rd(1'b0, r); chk("R9 specific eoi", r, 8'h00);
            wr(1'b0, 8'h0A);
            drive(8'h00);
        end

        // pair sweep: lower level wins, other waits until its eoi
        for (int a = 0; a < 8; a++) begin
            for (int b = a + 1; b < 8; b++) begin
                drive(8'(1 << a) | 8'(1 << b));
                do_ack(v, vl);
                chk("R7 pair winner", v, 8'h08 | 8'(a));
                chk("R8 lower level held", {7'd0, intr}, 8'h00);
                wr(1'b0, 8'h60 | 8'(a));
                chk("R8 released after eoi", {7'd0, intr}, 8'h01);
                do_ack(v, vl);
                chk("R8 second grant", v, 8'h08 | 8'(b));
                wr(1'b0, 8'h60 | 8'(b));
                drive(8'h00);
            end
        end

        // nesting: 5 in service, 2 preempts
        drive(8'h20);
        do_ack(v, vl); chk("R7 level 5 grant", v, 8'h0D);
        drive(8'h24);
        chk("R8 higher preempts", {7'd0, intr}, 8'h01);
        do_ack(v, vl); chk("R8 nested vector", v, 8'h0A);
        wr(1'b0, 8'h0B);
        rd(1'b0, r); chk("R8 two in service", r, 8'h24);
        wr(1'b0, 8'h08);
        rd(1'b0, r); chk("R10 select unchanged", r, 8'h24);
        wr(1'b0, 8'h0A);
        rd(1'b0, r); chk("R10 pending selected", r, 8'h00);
        wr(1'b0, 8'h0B);
        wr(1'b0, 8'h65);
        rd(1'b0, r); chk("R9 only level 5 cleared", r, 8'h04);
        wr(1'b0, 8'h62);
        rd(1'b0, r); chk("R9 level 2 cleared", r, 8'h00);
        wr(1'b0, 8'h0A);
        drive(8'h00);

        // mask sweep with all lines raised
        for (int m = 0; m < 256; m++) begin
            wr(1'b1, 8'(m));
            drive(8'hFF);
            rd(1'b0, r); chk("R5 pending despite mask", r, 8'hFF);
            chk("R12 intr vs mask", {7'd0, intr}, (m != 255) ? 8'h01 : 8'h00);
            do_ack(v, vl);
            if (m != 255) begin
                chk("R7 lowest unmasked wins", v, 8'h08 | 8'(lowest_zero(8'(m))));
                wr(1'b0, 8'h60 | 8'(lowest_zero(8'(m))));
            end else begin
                chk("R11 all masked spurious", v, 8'h0F);
                wr(1'b0, 8'h0B);
                rd(1'b0, r); chk("R11 nothing in service", r, 8'h00);
                wr(1'b0, 8'h0A);
            end
            drive(8'h00);
        end
        wr(1'b1, 8'h00);

        // spurious: request drops before acknowledge
        drive(8'h08);
        chk("R12 intr raised", {7'd0, intr}, 8'h01);
        drive(8'h00);
        do_ack(v, vl); chk("R11 dropped request vector", v, 8'h0F);
        wr(1'b0, 8'h0B);
        rd(1'b0, r); chk("R11 no in-service bit", r, 8'h00);
        wr(1'b0, 8'h0A);
        wr(1'b1, 8'h80);
        drive(8'h10);
        drive(8'h00);
        do_ack(v, vl); chk("R11 spurious with level 7 masked", v, 8'h0F);
        wr(1'b1, 8'h00);

        // restart clears state; switch to automatic mode, base 0x20
        drive(8'h02);
        do_ack(v, vl); chk("R3 level 1 vector", v, 8'h09);
        wr(1'b0, 8'h0B);
        wr(1'b0, 8'h11);
        rd(1'b0, r); chk("R2 restart selects pending", r, 8'h00);
        wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h03);
        rd(1'b1, r); chk("R2 mask kept across setup", r, 8'h00);
        wr(1'b0, 8'h0B);
        rd(1'b0, r); chk("R2 restart clears in-service", r, 8'h00);
        drive(8'h00);

        drive(8'h10);
        do_ack(v, vl); chk("R4 auto vector", v, 8'h24);
        rd(1'b0, r); chk("R4 nothing left in service", r, 8'h00);
        drive(8'h50);
        chk("R4 lower level grantable", {7'd0, intr}, 8'h01);
        do_ack(v, vl); chk("R4 second auto vector", v, 8'h26);
        drive(8'h00);

        // single configuration: no cascade word
        wr(1'b0, 8'h13); wr(1'b1, 8'h40); wr(1'b1, 8'h01);
        rd(1'b1, r); chk("R2 no cascade word mask kept", r, 8'h00);
        wr(1'b1, 8'h55);
        rd(1'b1, r); chk("R2 next odd write is mask", r, 8'h55);
        drive(8'h02);
        do_ack(v, vl); chk("R2 new base vector", v, 8'h41);
        wr(1'b0, 8'h61);
        drive(8'h00);

        // single configuration without mode word: normal eoi
        wr(1'b0, 8'h12); wr(1'b1, 8'h18); wr(1'b1, 8'hAA);
        rd(1'b1, r); chk("R2 base only then mask", r, 8'hAA);
        drive(8'h01);
        do_ack(v, vl); chk("R2 base 0x18 vector", v, 8'h18);
        wr(1'b0, 8'h0B);
        rd(1'b0, r); chk("R2 restart leaves normal mode", r, 8'h01);
        wr(1'b0, 8'h60);
        drive(8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule